// File: doc/BRIEF.md
# Segment Descriptor Table Lookup Unit

This block resolves 16-bit segment selectors into 8-byte segment descriptors. It holds two table registers. The global table register has a base and a 16-bit byte limit. The local table register caches a selector, base, 20-bit limit and access rights. For each request the block computes the descriptor's linear address from the chosen table. It checks that all eight descriptor bytes lie inside that table's limit, then fetches the descriptor as two 32-bit words over a valid/ready memory read port. Each request ends with a one-cycle done pulse that carries a fault code and the descriptor.

The block supports three request kinds:
- A segment-register load, which accepts the null selector without touching memory.
- A memory access check, which rejects the null selector.
- A local table load. It reads a local-table system descriptor out of the global table and caches it, so that later local lookups take the base and limit from the register and need no extra read.

Top module: `seg_desc_lookup`

## Requirements
- R1: After reset, the global base and limit are 0, `ltab_valid` is 0, `req_ready` is 1 and `mem_req` is 0. With limit 0, a global lookup of index 1 faults with the limit code.
- R2: Selector bits [15:3] are the index, bit 2 selects local (1) or global (0), and bits [1:0] are ignored. A lookup reads the word at base+index*8, then the word at base+index*8+4. `rsp_desc` = {second word, first word}.
- R3: A lookup is legal only if index*8+7 <= limit of the chosen table. Otherwise `rsp_fault` = 2 and no memory read is made. index*8+7 == limit is legal.
- R4: A load request (`req_op` 00 or 11) whose selector has bits [15:2] all zero completes with fault 0, `rsp_desc` 0 and no memory read.
- R5: An access request (`req_op` 01) with a null selector completes with fault 1 and no memory read.
- R6: A local lookup while `ltab_valid` is 0 completes with fault 3 and no memory read.
- R7: A local table load (`req_op` 10) whose selector has bit 2 set completes with fault 4, makes no read and leaves the local table register unchanged.
- R8: A local table load completes with fault 5 if descriptor bits [44:40] (second word bits [12:8]) are not 5'b00010. The local table register is left unchanged and `rsp_desc` holds the fetched descriptor.
- R9: A successful local table load sets `ltab_valid`. It caches the selector and three fields from the second word W1 and first word W0: base = {W1[31:24],W1[7:0],W0[31:16]}, limit = {W1[19:16],W0[15:0]}, and access rights = {W1[23:20],W1[15:8]}. Later local lookups use the cached base and limit with exactly two reads.
- R10: A local table load of a null selector clears `ltab_valid` and completes with fault 0 and no read.
- R11: `req_ready` is high only when idle. `mem_req` and `mem_addr` hold until `mem_ready`. Each accepted request yields exactly one `rsp_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtab_wr | input | 1 | Write the global table register |
| gtab_wr_base | input | 32 | New global table base |
| gtab_wr_limit | input | 16 | New global table byte limit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 00/11 load, 01 access, 10 local table load |
| req_sel | input | 16 | Segment selector |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 3 | 0 none, 1 null, 2 limit, 3 local invalid, 4 local selector, 5 bad type |
| rsp_desc | output | 64 | Fetched descriptor |
| mem_req | output | 1 | Memory read valid |
| mem_addr | output | 32 | Memory read address |
| mem_ready | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 32 | Read data |
| ltab_valid | output | 1 | Local table register holds a descriptor |
| ltab_sel | output | 16 | Cached local table selector |
| ltab_base | output | 32 | Cached local table base |
| ltab_limit | output | 20 | Cached local table limit |
| ltab_ar | output | 12 | Cached local table access rights |

## Verification
The bench probes the last legal global index, where limit equals index*8+7, and the first index beyond it. An off-by-one comparison would either fault the legal entry or issue reads for the illegal one. It separates null selectors by request kind and gives the null selector a nonzero requested privilege level. A design that ignored that field, or that applied the wrong null rule, would return the wrong fault code or make spurious reads. It covers several bad local table loads: a wrong descriptor type, a local-table selector, a null selector, and a lookup before any load. Each case checks that the cached register either stays unchanged or is dropped as required. Memory latency varies from request to request, so a design that did not hold the address until ready would return mixed descriptor words.

// File: rtl/seg_desc_lookup.sv
module seg_desc_lookup #(
  parameter int GLIM_W = 16,
  parameter int LLIM_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gtab_wr,
  input  logic [31:0]       gtab_wr_base,
  input  logic [GLIM_W-1:0] gtab_wr_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [15:0]       req_sel,
  output logic              rsp_done,
  output logic [2:0]        rsp_fault,
  output logic [63:0]       rsp_desc,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              ltab_valid,
  output logic [15:0]       ltab_sel,
  output logic [31:0]       ltab_base,
  output logic [LLIM_W-1:0] ltab_limit,
  output logic [11:0]       ltab_ar
);
  localparam logic [1:0] OP_ACC = 2'b01;
  localparam logic [1:0] OP_LT  = 2'b10;
  localparam logic [2:0] F_NONE = 3'd0, F_NULL = 3'd1, F_LIMIT = 3'd2,
                         F_LINV = 3'd3, F_LTI  = 3'd4, F_TYPE  = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_RD0, S_RD1} st_t;
  st_t state;

  logic [31:0]       gtab_base;
  logic [GLIM_W-1:0] gtab_limit;
  logic [31:0]       addr_q, lo_q;
  logic [15:0]       sel_q;
  logic [1:0]        op_q;

  wire [12:0]       idx     = req_sel[15:3];
  wire              ti      = req_sel[2];
  wire              is_null = (req_sel[15:2] == 14'd0);
  wire [LLIM_W-1:0] lim     = ti ? ltab_limit : LLIM_W'(gtab_limit);
  wire              over    = LLIM_W'({idx, 3'b111}) > lim;
  wire [31:0]       base    = ti ? ltab_base : gtab_base;
  wire              accept  = req_valid && req_ready;

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state != S_IDLE);
  assign mem_addr  = (state == S_RD1) ? addr_q + 32'd4 : addr_q;

  logic       early_done;
  logic [2:0] early_fault;
  always_comb begin
    early_done  = 1'b1;
    early_fault = F_NONE;
    if (is_null) begin
      if (req_op == OP_ACC) early_fault = F_NULL;
    end else if (req_op == OP_LT && ti) early_fault = F_LTI;
    else if (ti && !ltab_valid)         early_fault = F_LINV;
    else if (over)                      early_fault = F_LIMIT;
    else                                early_done  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      gtab_base  <= '0;
      gtab_limit <= '0;
      addr_q     <= '0;
      lo_q       <= '0;
      sel_q      <= '0;
      op_q       <= '0;
      rsp_done   <= 1'b0;
      rsp_fault  <= F_NONE;
      rsp_desc   <= '0;
      ltab_valid <= 1'b0;
      ltab_sel   <= '0;
      ltab_base  <= '0;
      ltab_limit <= '0;
      ltab_ar    <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (gtab_wr) begin
        gtab_base  <= gtab_wr_base;
        gtab_limit <= gtab_wr_limit;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          sel_q  <= req_sel;
          addr_q <= base + {16'd0, idx, 3'b000};
          if (early_done) begin
            rsp_done  <= 1'b1;
            rsp_fault <= early_fault;
            rsp_desc  <= '0;
            if (is_null && req_op == OP_LT) ltab_valid <= 1'b0;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (mem_ready) begin
          lo_q  <= mem_rdata;
          state <= S_RD1;
        end
        S_RD1: if (mem_ready) begin
          state     <= S_IDLE;
          rsp_done  <= 1'b1;
          rsp_desc  <= {mem_rdata, lo_q};
          rsp_fault <= F_NONE;
          if (op_q == OP_LT) begin
            if (mem_rdata[12:8] != 5'b00010) begin
              rsp_fault <= F_TYPE;
            end else begin
              ltab_valid <= 1'b1;
              ltab_sel   <= sel_q;
              ltab_base  <= {mem_rdata[31:24], mem_rdata[7:0], lo_q[31:16]};
              ltab_limit <= LLIM_W'({mem_rdata[19:16], lo_q[15:0]});
              ltab_ar    <= {mem_rdata[23:20], mem_rdata[15:8]};
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
  p_null_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_null && req_op == OP_ACC |=> rsp_done && rsp_fault == F_NULL && !mem_req);
  p_null_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_null && req_op != OP_ACC && req_op != OP_LT
      |=> rsp_done && rsp_fault == F_NONE && !mem_req);
  p_linv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ti && !ltab_valid && req_op != OP_LT |=> rsp_done && rsp_fault == F_LINV);
  p_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_null && !ti && over |=> rsp_done && rsp_fault == F_LIMIT && !mem_req);
  p_ltab_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltab_valid) |-> $past(state == S_RD1 && mem_ready && op_q == OP_LT));
endmodule

// File: tb/seg_desc_lookup_tb_top.sv
`timescale 1ns/1ps
module seg_desc_lookup_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, gtab_wr, req_valid, req_ready, rsp_done, mem_req, mem_ready, ltab_valid;
  logic [31:0] gtab_wr_base, mem_addr, mem_rdata, ltab_base;
  logic [15:0] gtab_wr_limit, req_sel, ltab_sel;
  logic [1:0]  req_op;
  logic [2:0]  rsp_fault;
  logic [63:0] rsp_desc;
  logic [19:0] ltab_limit;
  logic [11:0] ltab_ar;

  seg_desc_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .gtab_wr(gtab_wr), .gtab_wr_base(gtab_wr_base),
    .gtab_wr_limit(gtab_wr_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sel(req_sel), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_desc(rsp_desc), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .ltab_valid(ltab_valid), .ltab_sel(ltab_sel),
    .ltab_base(ltab_base), .ltab_limit(ltab_limit), .ltab_ar(ltab_ar));

  int checks = 0, fails = 0, rd_cnt = 0;
  logic [31:0] mem [0:255];
  logic [2:0]  q_fault [$];
  logic [63:0] q_desc [$];
  string       q_tag [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  int wait_cnt = 0, pat = 0;
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wait_cnt  <= pat;
      pat       <= (pat + 1) % 3;
    end else if (rst_n && mem_req) begin
      if (wait_cnt == 0) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[mem_addr[9:2]];
        rd_cnt    <= rd_cnt + 1;
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (q_fault.size() == 0) chk(1'b0, "R11", "unexpected rsp_done", 64'd1, 64'd0);
      else begin
        automatic logic [2:0]  ef = q_fault.pop_front();
        automatic logic [63:0] ed = q_desc.pop_front();
        automatic string       tg = q_tag.pop_front();
        chk(rsp_fault == ef && rsp_desc == ed, tg, "response", {rsp_fault, rsp_desc[59:0]},
            {ef, ed[59:0]});
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] sel, input logic [2:0] ef,
                       input logic [63:0] ed, input int ereads, input string rq);
    int r0;
    r0 = rd_cnt;
    q_fault.push_back(ef); q_desc.push_back(ed); q_tag.push_back(rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    if (ereads > 0) chk(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
    while (q_fault.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(rd_cnt - r0 == ereads, rq, "read count", rd_cnt - r0, ereads);
  endtask

  task automatic gtab_set(input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    gtab_wr = 1'b1; gtab_wr_base = b; gtab_wr_limit = l;
    @(negedge clk);
    gtab_wr = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[66] = 32'h1111_2222; mem[67] = 32'h3344_9A55;
    mem[68] = 32'h0200_001F; mem[69] = 32'h0000_8200;
    mem[70] = 32'h0300_001F; mem[71] = 32'h0000_8900;
    mem[78] = 32'hAAAA_5555; mem[79] = 32'h00CF_9200;
    mem[134] = 32'hDEAD_BEEF; mem[135] = 32'h0BAD_F00D;
    rst_n = 1'b0; gtab_wr = 1'b0; gtab_wr_base = '0; gtab_wr_limit = '0;
    req_valid = 1'b0; req_op = '0; req_sel = '0; mem_ready = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !ltab_valid && !mem_req, "R1", "reset state",
        {req_ready, ltab_valid, mem_req}, 3'b100);
    issue(2'b00, 16'h0008, 3'd2, 64'd0, 0, "R1");
    gtab_set(32'h100, 16'h003F);
    issue(2'b00, 16'h0008, 3'd0, 64'h3344_9A55_1111_2222, 2, "R2");
    issue(2'b00, 16'h000B, 3'd0, 64'h3344_9A55_1111_2222, 2, "R2");
    issue(2'b00, 16'h0003, 3'd0, 64'd0, 0, "R4");
    issue(2'b11, 16'h0000, 3'd0, 64'd0, 0, "R4");
    issue(2'b01, 16'h0000, 3'd1, 64'd0, 0, "R5");
    issue(2'b01, 16'h0002, 3'd1, 64'd0, 0, "R5");
    issue(2'b01, 16'h0038, 3'd0, 64'h00CF_9200_AAAA_5555, 2, "R3");
    issue(2'b01, 16'h0040, 3'd2, 64'd0, 0, "R3");
    issue(2'b00, 16'h0004, 3'd3, 64'd0, 0, "R6");
    issue(2'b10, 16'h000C, 3'd4, 64'd0, 0, "R7");
    chk(!ltab_valid, "R7", "ltab unchanged", ltab_valid, 0);
    issue(2'b10, 16'h0018, 3'd5, 64'h0000_8900_0300_001F, 2, "R8");
    chk(!ltab_valid, "R8", "ltab unchanged", ltab_valid, 0);
    issue(2'b10, 16'h0010, 3'd0, 64'h0000_8200_0200_001F, 2, "R9");
    chk(ltab_valid && ltab_sel == 16'h0010 && ltab_base == 32'h200 && ltab_limit == 20'h1F
        && ltab_ar == 12'h082, "R9", "ltab contents",
        {ltab_valid, ltab_sel, ltab_base, ltab_limit[7:0]}, {1'b1, 16'h0010, 32'h200, 8'h1F});
    issue(2'b00, 16'h001F, 3'd0, 64'h0BAD_F00D_DEAD_BEEF, 2, "R9");
    issue(2'b00, 16'h0024, 3'd2, 64'd0, 0, "R3");
    issue(2'b10, 16'h0018, 3'd5, 64'h0000_8900_0300_001F, 2, "R8");
    chk(ltab_valid && ltab_base == 32'h200, "R8", "ltab kept", {ltab_valid, ltab_base},
        {1'b1, 32'h200});
    issue(2'b10, 16'h0000, 3'd0, 64'd0, 0, "R10");
    chk(!ltab_valid, "R10", "ltab cleared", ltab_valid, 0);
    issue(2'b00, 16'h001C, 3'd3, 64'd0, 0, "R10");
    summary();
  end
endmodule